// File: doc/BRIEF.md
# Prescaled Dual-Resolution PWM Generator

This block drives one pulse-width-modulated output. Settings arrive over a byte-wide write-only register port. The PWM period is a chain of four stages: one of three reference tick streams, a fixed pre-divider, a power-of-two exponent stage and a 6-bit or 9-bit period counter. The output is high while the period counter is below the programmed duty value.

All period and duty settings are double-buffered. Bus writes land in shadow registers. A write of 1 to the sync register arms a transfer into the active generator. When the hold-until-boundary option is set and the generator is running, the transfer waits for the counter to wrap, so the output never shows a partial period. A separate enable register gates the output at once, outside the double buffer.

The reference clocks themselves are not part of the block. They enter as single-cycle tick enables that are synchronous to the system clock.

Top module: `pwm_prescaled_gen`

## Requirements
- R1: Register offsets on `reg_addr`:
  - 0: bits 1:0 are the clock select and bit 2 is the size bit.
  - 1: bits 2:0 are the exponent m and bits 5:4 are the pre-divide index.
  - 2: bit 0 is the hold-until-boundary bit.
  - 3: the duty low byte.
  - 4: bit 0 is duty bit 8.
  - 5: sync; bit 0 must be 1 to take effect.
  - 6: bit 0 is the output enable.
  
  Writes to offsets 0 to 4 do not change the output until a sync transfer.
- R2: Pre-divide index 0, 1, 2 and 3 selects a ratio of 1, 3, 5 and 6. The period counter advances once for every ratio×2^m selected ticks.
- R3: Clock select 1, 2 and 3 takes `ref_tick[0]`, `ref_tick[1]` and `ref_tick[2]`. Clock select 0 selects nothing, and the counter and the output hold.
- R4: The period counter changes only on a prescaler step or a transfer.
- R5: With the size bit at 1 the counter runs from 0 to 511. With the size bit at 0 it runs from 0 to 63. It then wraps to 0.
- R6: The duty value is {bit 8, low byte} in 9-bit mode and low byte bits 5:0 in 6-bit mode. The output is high while enabled and counter < duty. A duty of 0 gives a constant low, and a duty of 2^N−1 gives a low output for one count per period.
- R7: A transfer becomes pending at the sync write. It completes on the next clock when the pending hold bit is 0 or the active clock select is 0. Each transfer restarts the prescaler and the counter at 0.
- R8: With the pending hold bit at 1 and a running active clock, the transfer completes only on the cycle in which the counter wraps.
- R9: Enable at 0 forces the output low from the next clock on. Enable is not double-buffered.
- R10: Reset clears all shadow and active registers, the pending flag and the enable, so the output is low.
- R11: A sync write with bit 0 at 0 has no effect, and neither does a write to offsets 7 to 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register offset |
| reg_wdata | input | 8 | Register write data |
| ref_tick | input | 3 | Reference tick enables, one per reference clock |
| pwm_out | output | 1 | PWM output |

## Verification
The assertions check the following on every cycle:
- the prescaler count stays below its span;
- the counter stays within the active size;
- the counter holds without a step and moves on a step;
- the active settings change only at a transfer;
- a held transfer lands only on a wrap.

Only the bench scenarios can show the things that need a whole period:
- the duty-to-high-time ratio for each size;
- the length of each divide ratio;
- that the output keeps its old duty until the wrap;
- that unused offsets and a sync without bit 0 leave the output unchanged.

// File: rtl/pwm_gen_pkg.sv
package pwm_gen_pkg;
  localparam int ADDR_W   = 4;
  localparam int DATA_W   = 8;
  localparam int NREF     = 3;
  localparam int CSEL_W   = 2;
  localparam int EXP_W    = 3;
  localparam int DIVIDX_W = 2;
  localparam int DUTY_W   = 9;
  localparam int NARROW_W = 6;
  localparam int PRESC_W  = 10;

  localparam int OFS_SIZE_CLK = 0;
  localparam int OFS_DIV_EXP  = 1;
  localparam int OFS_TYPE     = 2;
  localparam int OFS_DUTY_LO  = 3;
  localparam int OFS_DUTY_HI  = 4;
  localparam int OFS_SYNC     = 5;
  localparam int OFS_ENABLE   = 6;

  typedef struct packed {
    logic                wide;
    logic [CSEL_W-1:0]   csel;
    logic [EXP_W-1:0]    expo;
    logic [DIVIDX_W-1:0] div_idx;
    logic                hold;
    logic [DATA_W-1:0]   duty_lo;
    logic                duty_hi;
  } pwm_cfg_t;

  // Number of selected ticks per counter step: ratio * 2^m
  function automatic logic [PRESC_W-1:0] tick_span(input logic [DIVIDX_W-1:0] div_idx,
                                                   input logic [EXP_W-1:0] expo);
    logic [PRESC_W-1:0] r;
    case (div_idx)
      2'd0:    r = PRESC_W'(1);
      2'd1:    r = PRESC_W'(3);
      2'd2:    r = PRESC_W'(5);
      default: r = PRESC_W'(6);
    endcase
    return r << expo;
  endfunction

  function automatic logic [DUTY_W-1:0] top_count(input logic wide);
    return wide ? DUTY_W'((1 << DUTY_W) - 1) : DUTY_W'((1 << NARROW_W) - 1);
  endfunction

  function automatic logic [DUTY_W-1:0] duty_of(input pwm_cfg_t c);
    return c.wide ? {c.duty_hi, c.duty_lo}
                  : {{(DUTY_W-NARROW_W){1'b0}}, c.duty_lo[NARROW_W-1:0]};
  endfunction
endpackage

// File: rtl/pwm_regbank.sv
module pwm_regbank
  import pwm_gen_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output pwm_cfg_t          shadow,
  output logic              enable_q,
  output logic              sync_req
);
  logic hit_size, hit_div, hit_type, hit_lo, hit_hi, hit_sync, hit_en;

  assign hit_size = reg_wr && (reg_addr == ADDR_W'(OFS_SIZE_CLK));
  assign hit_div  = reg_wr && (reg_addr == ADDR_W'(OFS_DIV_EXP));
  assign hit_type = reg_wr && (reg_addr == ADDR_W'(OFS_TYPE));
  assign hit_lo   = reg_wr && (reg_addr == ADDR_W'(OFS_DUTY_LO));
  assign hit_hi   = reg_wr && (reg_addr == ADDR_W'(OFS_DUTY_HI));
  assign hit_sync = reg_wr && (reg_addr == ADDR_W'(OFS_SYNC));
  assign hit_en   = reg_wr && (reg_addr == ADDR_W'(OFS_ENABLE));

  assign sync_req = hit_sync && reg_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow   <= '0;
      enable_q <= 1'b0;
    end else begin
      if (hit_size) begin
        shadow.wide <= reg_wdata[2];
        shadow.csel <= reg_wdata[1:0];
      end
      if (hit_div) begin
        shadow.expo    <= reg_wdata[2:0];
        shadow.div_idx <= reg_wdata[5:4];
      end
      if (hit_type) shadow.hold    <= reg_wdata[0];
      if (hit_lo)   shadow.duty_lo <= reg_wdata;
      if (hit_hi)   shadow.duty_hi <= reg_wdata[0];
      if (hit_en)   enable_q       <= reg_wdata[0];
    end
  end
endmodule

// File: rtl/pwm_prescaler.sv
module pwm_prescaler
  import pwm_gen_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic [CSEL_W-1:0]  csel,
  input  logic [NREF-1:0]    ref_tick,
  input  logic [PRESC_W-1:0] span,
  output logic               step
);
  logic               tick_sel;
  logic [PRESC_W-1:0] presc_q;

  always_comb begin
    case (csel)
      2'd1:    tick_sel = ref_tick[0];
      2'd2:    tick_sel = ref_tick[1];
      2'd3:    tick_sel = ref_tick[2];
      default: tick_sel = 1'b0;
    endcase
  end

  assign step = tick_sel && (presc_q == span - PRESC_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        presc_q <= '0;
    else if (clear)    presc_q <= '0;
    else if (tick_sel) presc_q <= step ? '0 : presc_q + PRESC_W'(1);
  end

  assert_presc_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    presc_q < span);
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter
  import pwm_gen_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              step,
  input  logic              wide,
  output logic [DUTY_W-1:0] cnt,
  output logic              wrap
);
  logic [DUTY_W-1:0] cnt_q;

  assign wrap = step && (cnt_q == top_count(wide));
  assign cnt  = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (clear)  cnt_q <= '0;
    else if (step)   cnt_q <= wrap ? '0 : cnt_q + DUTY_W'(1);
  end

  assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= top_count(wide));
  assert_cnt_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !clear) |=> $stable(cnt_q));
  assert_cnt_moves_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clear) |=> (cnt_q != $past(cnt_q)));
endmodule

// File: rtl/pwm_prescaled_gen.sv
module pwm_prescaled_gen
  import pwm_gen_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic [NREF-1:0]   ref_tick,
  output logic              pwm_out
);
  pwm_cfg_t          shadow, active_q;
  logic              enable_q, sync_req, pending_q, commit;
  logic              step, wrap;
  logic [DUTY_W-1:0] cnt;
  logic [PRESC_W-1:0] span;

  pwm_regbank u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .shadow(shadow), .enable_q(enable_q), .sync_req(sync_req)
  );

  assign span = tick_span(active_q.div_idx, active_q.expo);

  pwm_prescaler u_presc (
    .clk(clk), .rst_n(rst_n), .clear(commit), .csel(active_q.csel),
    .ref_tick(ref_tick), .span(span), .step(step)
  );

  pwm_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .clear(commit), .step(step),
    .wide(active_q.wide), .cnt(cnt), .wrap(wrap)
  );

  // Transfer: immediate unless holding for the boundary of a running period
  assign commit = pending_q && (!shadow.hold || (active_q.csel == '0) || wrap);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending_q <= 1'b0;
      active_q  <= '0;
    end else begin
      if (sync_req)    pending_q <= 1'b1;
      else if (commit) pending_q <= 1'b0;
      if (commit)      active_q  <= shadow;
    end
  end

  assign pwm_out = enable_q && (cnt < duty_of(active_q));

  assert_active_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(active_q));
  assert_hold_on_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && shadow.hold && (active_q.csel != '0)) |-> wrap);
endmodule

// File: tb/pwm_prescaled_gen_bench.sv
`timescale 1ns/1ps
module pwm_prescaled_gen_bench;
  logic       clk = 1'b0, rst_n = 1'b0, reg_wr = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [2:0] ref_tick = '0;
  logic       pwm_out;

  int    checks = 0, failures = 0, cyc = 0;
  string phase = "R10";
  bit    cmp_on = 1'b0, done = 1'b0;

  always #2 clk = ~clk;

  pwm_prescaled_gen u_pwm_prescaled_gen (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .ref_tick(ref_tick), .pwm_out(pwm_out)
  );

  // Free-running reference ticks: every cycle, every 2nd, every 3rd
  always @(negedge clk) begin
    cyc++;
    ref_tick = {1'b1, (cyc % 2) == 0, (cyc % 3) == 0};
  end

  // Behavioural reference model
  int ratio [4] = '{1, 3, 5, 6};
  int s_wide, s_cs, s_exp, s_div, s_hold, s_lo, s_hi;
  int a_wide, a_cs, a_exp, a_div, a_hold, a_lo, a_hi;
  int m_en, m_pend, m_presc, m_cnt;
  bit m_out;

  always @(posedge clk) begin
    int tick, len, mx, duty;
    bit stp, wrp, com;
    if (!rst_n) begin
      s_wide = 0; s_cs = 0; s_exp = 0; s_div = 0; s_hold = 0; s_lo = 0; s_hi = 0;
      a_wide = 0; a_cs = 0; a_exp = 0; a_div = 0; a_hold = 0; a_lo = 0; a_hi = 0;
      m_en = 0; m_pend = 0; m_presc = 0; m_cnt = 0;
    end else begin
      tick = (a_cs == 0) ? 0 : int'(ref_tick[a_cs-1]);
      len  = ratio[a_div] * (1 << a_exp);
      mx   = a_wide ? 511 : 63;
      stp  = (tick != 0) && (m_presc == len - 1);
      wrp  = stp && (m_cnt == mx);
      com  = (m_pend != 0) && (s_hold == 0 || a_cs == 0 || wrp);
      if (com) begin
        a_wide = s_wide; a_cs = s_cs; a_exp = s_exp; a_div = s_div;
        a_hold = s_hold; a_lo = s_lo; a_hi = s_hi;
        m_presc = 0; m_cnt = 0;
      end else begin
        if (tick != 0) m_presc = stp ? 0 : m_presc + 1;
        if (stp) m_cnt = (m_cnt == mx) ? 0 : m_cnt + 1;
      end
      if (reg_wr && reg_addr == 5 && reg_wdata[0]) m_pend = 1;
      else if (com) m_pend = 0;
      if (reg_wr) begin
        case (reg_addr)
          4'd0: begin s_wide = int'(reg_wdata[2]); s_cs = int'(reg_wdata[1:0]); end
          4'd1: begin s_exp = int'(reg_wdata[2:0]); s_div = int'(reg_wdata[5:4]); end
          4'd2: s_hold = int'(reg_wdata[0]);
          4'd3: s_lo = int'(reg_wdata);
          4'd4: s_hi = int'(reg_wdata[0]);
          4'd6: m_en = int'(reg_wdata[0]);
          default: ;
        endcase
      end
    end
    duty  = a_wide != 0 ? a_hi * 256 + a_lo : a_lo % 64;
    m_out = (m_en != 0) && (m_cnt < duty);
  end

  always @(negedge clk) begin
    if (cmp_on && !done) begin
      checks++;
      if (pwm_out !== m_out) begin
        failures++;
        $display("FAIL %s per-cycle pwm_out act=%0b exp=%0b", phase, pwm_out, m_out);
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 4'(a); reg_wdata = 8'(d);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic high_count(input int n, output int h);
    h = 0;
    repeat (n) begin
      @(negedge clk);
      h += int'(pwm_out);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1'b1;
      failures++;
      $display("FAIL R10 watchdog expired act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int h, first, changes;
    settle(3);
    chk("R10 output low in reset", int'(pwm_out), 0);
    rst_n = 1'b1;
    cmp_on = 1'b1;
    settle(5);
    chk("R10 output low after reset", int'(pwm_out), 0);

    // R1: shadow writes alone leave output low
    phase = "R1";
    wr(0, 3); wr(1, 0); wr(2, 0); wr(3, 20); wr(6, 1);
    settle(10);
    chk("R1 no effect before sync", int'(pwm_out), 0);

    // R6 / R5: 6-bit, tick every cycle, duty 20
    phase = "R6";
    wr(5, 1); settle(4);
    high_count(64, h); chk("R6 6-bit duty 20", h, 20);
    phase = "R5";
    high_count(64, h); chk("R5 6-bit period 64", h, 20);

    // R5 / R6: 9-bit, duty 300
    wr(0, 7); wr(3, 44); wr(4, 1); wr(5, 1); settle(4);
    high_count(512, h); chk("R5 9-bit duty 300 over 512", h, 300);

    // R6: 6-bit ignores bits 7:6 and bit 8
    phase = "R6";
    wr(0, 3); wr(3, 8'hC5); wr(5, 1); settle(4);
    high_count(64, h); chk("R6 6-bit uses low 6 bits", h, 5);

    // R2: ratio 5, m=1 -> span 10 ; ratio 6, m=0 -> span 6
    phase = "R2";
    wr(1, 8'h21); wr(5, 1); settle(4);
    high_count(640, h); chk("R2 ratio5 m1", h, 50);
    wr(1, 8'h30); wr(5, 1); settle(4);
    high_count(384, h); chk("R2 ratio6 m0", h, 30);

    // R3: clock select 1 (every 3rd cycle), 2 (every 2nd)
    phase = "R3";
    wr(1, 0); wr(0, 1); wr(5, 1); settle(4);
    high_count(192, h); chk("R3 select tick0", h, 15);
    wr(0, 2); wr(5, 1); settle(4);
    high_count(128, h); chk("R3 select tick1", h, 10);

    // R3 / R4: clock select 0 holds counter and output
    phase = "R4";
    wr(0, 3); wr(5, 1); settle(7);
    wr(0, 0); wr(5, 1); settle(2);
    first = int'(pwm_out); changes = 0;
    repeat (100) begin
      @(negedge clk);
      if (int'(pwm_out) != first) changes++;
    end
    chk("R3 R4 no clock holds output", changes, 0);

    // R7: immediate transfer restarts counter at 0
    phase = "R7";
    wr(0, 3); wr(3, 0); wr(5, 1); settle(70);
    wr(3, 16); wr(5, 1);
    high_count(16, h); chk("R7 restart highs 16", h, 16);
    @(negedge clk); chk("R7 low after 16", int'(pwm_out), 0);

    // R8: hold-until-boundary
    phase = "R8";
    wr(3, 10); wr(5, 1); settle(70);
    wr(2, 1); wr(5, 1); settle(70);
    wr(3, 40); wr(5, 1);
    settle(70);
    high_count(64, h); chk("R8 new duty after wrap", h, 40);

    // R9: enable gating
    phase = "R9";
    wr(6, 0); settle(2);
    high_count(64, h); chk("R9 disabled low", h, 0);
    wr(6, 1); settle(2);
    high_count(64, h); chk("R9 re-enabled", h, 40);

    // R11: sync with bit0 clear and unused offsets
    phase = "R11";
    wr(3, 12); wr(5, 8'hFE); settle(70);
    high_count(64, h); chk("R11 sync bit0 clear ignored", h, 40);
    wr(9, 8'hFF); wr(15, 0); wr(7, 0); settle(70);
    high_count(64, h); chk("R11 unused offsets ignored", h, 40);
    wr(5, 1); settle(70);
    high_count(64, h); chk("R11 real sync applies", h, 12);

    // R6: extremes
    phase = "R6";
    wr(3, 63); wr(5, 1); settle(70);
    high_count(64, h); chk("R6 max duty", h, 63);
    wr(3, 0); wr(5, 1); settle(70);
    high_count(64, h); chk("R6 zero duty", h, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule